// File: doc/BRIEF.md
# Banked Clock Divider with Output Control

This block turns one fast clock into four banks of four clock outputs and one feedback clock. The fast clock stands in for a multiplying oscillator running at several times the wanted output rates. Each bank carries a 2-bit ratio code that picks 3, 4, 6 or 12. The feedback path carries its own 2-bit code that picks 6, 12, 16 or 20.

A master reset holds every divider and drives the outputs low. A per-bank enable marks a bank as high impedance. High impedance is modelled as a flag beside the bank's data, with the data held at 0. A bypass select routes a reference straight to every output. A source select picks that reference from either the crystal input or the external reference input.

Each bank is driven by a single counter, so its four outputs are always identical. A new ratio code takes effect only when the current period ends.

Top module: `banked_clkdiv`

## Requirements
- R1: While `mreset` is 1, every bit of `bank_q` and `fb_q` reads 0 and no divider advances.
- R2: Bank b takes its code from `bank_div[2b+1:2b]`. Code 00 gives a period of 3 fast cycles, 01 gives 4, 10 gives 6 and 11 gives 12.
- R3: Feedback code `fb_div` 00 gives a period of 6 fast cycles, 01 gives 12, 10 gives 16 and 11 gives 20.
- R4: In each period of N fast cycles, a divided output is high for floor(N/2) cycles and low for the rest. Ratio 3 is therefore high for 1 cycle and low for 2.
- R5: On the first fast-clock edge after `mreset` falls, every divided output with pll_en=1 goes high on that same edge.
- R6: A change of ratio code lets the period in progress finish at the old ratio. The new ratio applies from the next period on.
- R7: The four outputs of one bank (`bank_q[4b+3:4b]`) are equal at all times.
- R8: When `bank_oe[b]` is 0, `bank_hiz[b]` is 1 and the bank's four data bits are 0, whether or not `mreset` is 1. When `bank_oe[b]` is 1, `bank_hiz[b]` is 0.
- R9: With `pll_en`=0 and `mreset`=0, enabled bank outputs and `fb_q` follow the reference selected by `src_xtal`: `xtal_in` when `src_xtal` is 1, `ref_ext` when it is 0. `mreset`=1 still forces them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock that all dividers count |
| mreset | input | 1 | Master reset, active high, asynchronous assert |
| pll_en | input | 1 | 1: outputs come from the dividers; 0: bypass to the reference |
| src_xtal | input | 1 | Reference select: 1 picks xtal_in, 0 picks ref_ext |
| ref_ext | input | 1 | External reference clock |
| xtal_in | input | 1 | Crystal oscillator clock |
| bank_div | input | 8 | Ratio code, 2 bits per bank, bank b at [2b+1:2b] |
| fb_div | input | 2 | Feedback ratio code |
| bank_oe | input | 4 | Output enable per bank |
| bank_q | output | 16 | Bank outputs, bank b at [4b+3:4b] |
| bank_hiz | output | 4 | High-impedance flag per bank |
| fb_q | output | 1 | Feedback output |

## Verification
The assertions assume that all control and reference inputs change away from rising edges of the fast clock. They also assume that `pll_en` holds steady for the cycle in which reset is released. The first-edge check depends on this. The bench keeps within these limits by driving every input on the falling edge. It also releases reset only after the codes and `pll_en` have settled. It sweeps all sixteen pairings of bank and feedback codes, adds a mid-period code change, and exercises enable against reset and bypass. Random trials with a fixed seed then cover further combinations of codes and outputs.

// File: rtl/banked_clkdiv.sv
`timescale 1ns/1ps
module banked_clkdiv #(
  parameter int BANKS = 4,
  parameter int LANES = 4,
  parameter int CODEW = 2,
  parameter int MAX_RATIO = 20
) (
  input  logic                   clk_fast,
  input  logic                   mreset,
  input  logic                   pll_en,
  input  logic                   src_xtal,
  input  logic                   ref_ext,
  input  logic                   xtal_in,
  input  logic [BANKS*CODEW-1:0] bank_div,
  input  logic [CODEW-1:0]       fb_div,
  input  logic [BANKS-1:0]       bank_oe,
  output logic [BANKS*LANES-1:0] bank_q,
  output logic [BANKS-1:0]       bank_hiz,
  output logic                   fb_q
);
  localparam int CW = $clog2(MAX_RATIO + 1);

  function automatic logic [CW-1:0] ratio_of(input logic is_fb, input logic [CODEW-1:0] code);
    logic [CW-1:0] r;
    if (is_fb) begin
      case (code)
        2'd0:    r = CW'(6);
        2'd1:    r = CW'(12);
        2'd2:    r = CW'(16);
        default: r = CW'(20);
      endcase
    end else begin
      case (code)
        2'd0:    r = CW'(3);
        2'd1:    r = CW'(4);
        2'd2:    r = CW'(6);
        default: r = CW'(12);
      endcase
    end
    return r;
  endfunction

  logic [BANKS:0] div_q;
  logic           ref_pick;

  assign ref_pick = src_xtal ? xtal_in : ref_ext;

  for (genvar g = 0; g <= BANKS; g++) begin : g_div
    localparam bit IS_FB = (g == BANKS);
    logic [CODEW-1:0] sel;
    logic [CW-1:0]    cnt, ratio, cnt_inc, next_ratio;
    logic             fresh, q;

    if (IS_FB) begin : g_fbsel
      assign sel = fb_div;
    end else begin : g_bksel
      assign sel = bank_div[g*CODEW +: CODEW];
    end

    assign next_ratio = ratio_of(IS_FB, sel);
    assign cnt_inc    = cnt + 1'b1;

    always_ff @(posedge clk_fast or posedge mreset) begin
      if (mreset) begin
        cnt   <= '0;
        ratio <= '0;
        fresh <= 1'b1;
        q     <= 1'b0;
      end else if (fresh || cnt == ratio - 1'b1) begin
        ratio <= next_ratio;
        cnt   <= '0;
        fresh <= 1'b0;
        q     <= 1'b1;
      end else begin
        cnt <= cnt_inc;
        q   <= cnt_inc < (ratio >> 1);
      end
    end

    assign div_q[g] = q;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic lvl;
    assign lvl = !mreset && (pll_en ? div_q[b] : ref_pick);
    assign bank_hiz[b] = !bank_oe[b];
    assign bank_q[b*LANES +: LANES] = {LANES{bank_oe[b] && lvl}};
  end

  assign fb_q = !mreset && (pll_en ? div_q[BANKS] : ref_pick);
endmodule

module banked_clkdiv_chk #(
  parameter int BANKS = 4,
  parameter int LANES = 4
) (
  input logic                   clk_fast,
  input logic                   mreset,
  input logic                   pll_en,
  input logic [BANKS-1:0]       bank_oe,
  input logic [BANKS*LANES-1:0] bank_q,
  input logic [BANKS-1:0]       bank_hiz,
  input logic                   fb_q
);
  // R1
  always @(posedge clk_fast)
    if (mreset)
      reset_low_chk: assert (bank_q == '0 && fb_q == 1'b0);

  // R5
  first_rise_chk: assert property (@(posedge clk_fast) disable iff (mreset)
    ($fell(mreset) && pll_en) |=> fb_q);

  for (genvar b = 0; b < BANKS; b++) begin : g_chk
    // R7
    bank_phase_chk: assert property (@(posedge clk_fast) disable iff (mreset)
      (bank_q[b*LANES +: LANES] == '0) || (bank_q[b*LANES +: LANES] == '1));
    // R8
    oe_off_chk: assert property (@(posedge clk_fast) disable iff (mreset)
      !bank_oe[b] |-> (bank_hiz[b] && bank_q[b*LANES +: LANES] == '0));
    // R8
    oe_on_chk: assert property (@(posedge clk_fast) disable iff (mreset)
      bank_oe[b] |-> !bank_hiz[b]);
  end
endmodule

bind banked_clkdiv banked_clkdiv_chk #(.BANKS(BANKS), .LANES(LANES)) u_chk (
  .clk_fast(clk_fast),
  .mreset(mreset),
  .pll_en(pll_en),
  .bank_oe(bank_oe),
  .bank_q(bank_q),
  .bank_hiz(bank_hiz),
  .fb_q(fb_q)
);

// File: tb/banked_clkdiv_tb.sv
`timescale 1ns/1ps
module banked_clkdiv_tb;
  logic        clk = 1'b0;
  logic        mreset, pll_en, src_xtal, ref_ext, xtal_in;
  logic [7:0]  bank_div;
  logic [1:0]  fb_div;
  logic [3:0]  bank_oe;
  logic [15:0] bank_q;
  logic [3:0]  bank_hiz;
  logic        fb_q;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  banked_clkdiv u_dut (
    .clk_fast(clk), .mreset(mreset), .pll_en(pll_en), .src_xtal(src_xtal),
    .ref_ext(ref_ext), .xtal_in(xtal_in), .bank_div(bank_div), .fb_div(fb_div),
    .bank_oe(bank_oe), .bank_q(bank_q), .bank_hiz(bank_hiz), .fb_q(fb_q)
  );

  function automatic int exp_bank(int c);
    case (c) 0: return 3; 1: return 4; 2: return 6; default: return 12; endcase
  endfunction
  function automatic int exp_fb(int c);
    case (c) 0: return 6; 1: return 12; 2: return 16; default: return 20; endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic sig(int idx);
    return (idx < 4) ? bank_q[idx*4] : fb_q;
  endfunction

  function automatic bit split(int idx);
    if (idx >= 4) return 1'b0;
    return !(bank_q[idx*4 +: 4] == 4'h0 || bank_q[idx*4 +: 4] == 4'hF);
  endfunction

  task automatic count_from_rise(int idx, output int hi, output int per, output bit sp);
    int lo;
    hi = 1; lo = 0; sp = split(idx);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      sp |= split(idx);
      if (sig(idx)) hi++; else break;
    end
    lo = 1;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      sp |= split(idx);
      if (sig(idx)) break; else lo++;
    end
    per = hi + lo;
  endtask

  task automatic meas(int idx, output int hi, output int per, output bit sp);
    logic prev;
    prev = sig(idx);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (!prev && sig(idx)) break;
      prev = sig(idx);
    end
    count_from_rise(idx, hi, per, sp);
  endtask

  task automatic restart(int bc, int fc);
    @(negedge clk);
    mreset = 1'b1;
    for (int b = 0; b < 4; b++) bank_div[b*2 +: 2] = 2'((bc + b) % 4);
    fb_div = 2'(fc);
    @(negedge clk);
    mreset = 1'b0;
  endtask

  task automatic check_out(int idx, int code, string tag);
    int hi, per, exp;
    bit sp;
    meas(idx, hi, per, sp);
    exp = (idx < 4) ? exp_bank(code) : exp_fb(code);
    chk(idx < 4 ? "R2" : "R3", {tag, " period"}, per, exp);
    chk("R4", {tag, " high time"}, hi, exp / 2);
    chk("R7", {tag, " lanes split"}, int'(sp), 0);
  endtask

  initial begin
    int hi, per, bc, fc, idx;
    bit sp;
    void'($urandom(32'd2024));
    mreset = 1'b1; pll_en = 1'b1; src_xtal = 1'b0; ref_ext = 1'b0; xtal_in = 1'b0;
    bank_div = '0; fb_div = '0; bank_oe = 4'hF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "bank_q in reset", int'(bank_q), 0);
    chk("R1", "fb_q in reset", int'(fb_q), 0);
    chk("R8", "hiz with oe high", int'(bank_hiz), 0);

    // R2 R3 R4 R5: all sixteen code pairings
    for (int b2 = 0; b2 < 4; b2++) begin
      for (int f2 = 0; f2 < 4; f2++) begin
        restart(b2, f2);
        @(negedge clk);
        chk("R5", "fb first rise", int'(fb_q), 1);
        chk("R5", "banks first rise", int'(bank_q), 16'hFFFF);
        for (int i = 0; i < 5; i++)
          check_out(i, (i < 4) ? (b2 + i) % 4 : f2, "sweep");
      end
    end

    // R6: code change mid-period
    @(negedge clk);
    mreset = 1'b1; bank_div = 8'b0000_0011; fb_div = 2'd0;
    @(negedge clk);
    mreset = 1'b0;
    @(negedge clk);
    chk("R5", "bank0 rise before change", int'(sig(0)), 1);
    bank_div[1:0] = 2'b00;
    count_from_rise(0, hi, per, sp);
    chk("R6", "period in progress keeps old ratio", per, 12);
    chk("R6", "high time in progress", hi, 6);
    count_from_rise(0, hi, per, sp);
    chk("R6", "next period uses new ratio", per, 3);

    // R8: enable off, while running and in reset
    bank_oe = 4'b1011;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R8", "hiz bank2 running", int'(bank_hiz[2]), 1);
      chk("R8", "data bank2 running", int'(bank_q[11:8]), 0);
    end
    chk("R8", "hiz other banks", int'(bank_hiz & 4'b1011), 0);
    mreset = 1'b1;
    @(negedge clk);
    chk("R8", "hiz bank2 over reset", int'(bank_hiz[2]), 1);
    chk("R8", "hiz bank0 in reset", int'(bank_hiz[0]), 0);
    chk("R1", "outputs low in reset with oe mix", int'(bank_q), 0);
    bank_oe = 4'hF;

    // R9: bypass path
    @(negedge clk);
    mreset = 1'b0; pll_en = 1'b0;
    for (int k = 0; k < 24; k++) begin
      logic e;
      @(negedge clk);
      src_xtal = 1'($urandom); ref_ext = 1'($urandom); xtal_in = 1'($urandom);
      #1;
      e = src_xtal ? xtal_in : ref_ext;
      chk("R9", "fb_q bypass", int'(fb_q), int'(e));
      chk("R9", "bank_q bypass", int'(bank_q), e ? 16'hFFFF : 0);
    end
    ref_ext = 1'b1; xtal_in = 1'b1; mreset = 1'b1;
    #1;
    chk("R9", "bypass under reset fb", int'(fb_q), 0);
    chk("R9", "bypass under reset banks", int'(bank_q), 0);
    @(negedge clk);
    pll_en = 1'b1;

    // random trials
    for (int t = 0; t < 40; t++) begin
      bc = int'($urandom % 4); fc = int'($urandom % 4); idx = int'($urandom % 5);
      restart(bc, fc);
      check_out(idx, (idx < 4) ? (bc + idx) % 4 : fc, "random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule